// File: doc/BRIEF.md
# GPIO Bank Register Front End

This block presents a bank of general-purpose pins to a simple 32-bit read/write bus. Each pin has its own 64-byte register window in which every register is a small field: the synchronised pad input, the output value, an active-low output enable, two interrupt mask bits (a per-pin mask and a group mask), a latched pending flag, a trigger type, and two glitch-filter settings (a stable-count limit and a prescale divider).

Each pin slice synchronises its pad through two flops and passes the result through a glitch filter. The filtered value goes to an edge/level detector, whose events latch into the pin's pending flag. Pins are gathered sixteen to a group. A read-only summary word for each group, in a separate address region, shows which pins in that group have an unmasked pending interrupt. One interrupt line per group is the OR of those bits. Software services a group line by reading the summary word, then clears each pending flag by writing zero to it.

Bus reads are combinational: `bus_rdata` reflects the addressed register during the cycle in which `bus_sel` is high and `bus_we` is low. Writes take effect at the rising clock edge on which `bus_sel` and `bus_we` are both high.

Top module: `gpio_bank`

## Requirements
- R1: Pin p's registers sit at byte address p*0x40 plus a word offset. The offsets are 0x00 input, 0x04 output, 0x08 output enable, 0x0C pin mask, 0x10 group mask, 0x14 pending, 0x18 trigger type (3 bits), 0x1C filter count (8 bits) and 0x20 filter prescale (16 bits). Each register reads back, zero-extended, the value last written to it, and a write reaches only the addressed pin.
- R2: The input register returns the pad level after a two-flop synchroniser. A pad change is visible on a read after two rising edges and not after one.
- R3: `pad_out` follows the output register. The output enable is active low: 1 releases the pad (`pad_oe`=0), and 0 drives it (`pad_oe`=1). Each change takes effect at the edge of the write.
- R4: After reset, every pin is released (output enable reads 1), both masks read 1, pending reads 0, the trigger type reads 4, both filter fields read 0, and every group line is low.
- R5: The trigger type selects edge events: 4 latches pending on a rising filtered input, 2 on a falling one, and 6 on both. An edge of the other polarity does not set pending.
- R6: The trigger type selects level events: 1 sets pending while the filtered input is high, and 0 sets it while the filtered input is low. A clear issued while the level is still active is overridden, so pending still reads 1 afterwards.
- R7: Writing 0 to a pin's pending register clears it. Writing 1 to that register has no effect.
- R8: A pending pin drives its group line only when both its pin mask and its group mask are 0. Group line g is the OR of such pins g*16 to g*16+15.
- R9: The word at 0x4000+4*g is read-only. Its bit n is 1 when pin g*16+n is pending with both masks 0.
- R10: With prescale P>0 and count C, a filtered input change needs the synchronised input to differ for (C+1)*P consecutive cycles. A shorter pulse is dropped. With P=0 the filter passes the synchronised input through with one cycle of delay.
- R11: Reads of windows for pins at or above 49, of offsets above 0x20, of summary words for groups at or above 4, and of summary bits for pins above 48 all return 0. Writes to those places have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid while a read is selected |
| pad_in | input | 49 | Pad levels from the pins |
| pad_out | output | 49 | Output value for each pin |
| pad_oe | output | 49 | Pad drive enable, active high |
| grp_irq | output | 4 | One interrupt line per group of 16 pins |

## Verification
The bound checker watches these rules on every cycle:
- the two-cycle latency of pin 0's input register;
- a write to pin 0's output or output-enable register reaching its pad outputs on the next cycle;
- zero read data for nonexistent pin windows and summary words;
- all pads released and all group lines low just after reset.

Only the directed scenarios can show:
- each trigger type's edge and level selectivity;
- level re-assertion over a clear;
- dropping of glitches shorter than the filter window;
- the AND of the two masks on the group line;
- the mapping of pins 17 and 48 onto their summary-word bits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 16;
    localparam int TRIG_W = 3;
    localparam int OFF_W  = 4;

    // Word index inside a 64-byte pin window (byte offset / 4).
    typedef enum logic [OFF_W-1:0] {
        OFF_IN    = 4'd0,
        OFF_OUT   = 4'd1,
        OFF_OEN   = 4'd2,
        OFF_IMASK = 4'd3,
        OFF_GMASK = 4'd4,
        OFF_PEND  = 4'd5,
        OFF_TRIG  = 4'd6,
        OFF_FCNT  = 4'd7,
        OFF_FPRE  = 4'd8
    } reg_off_e;

    localparam logic [TRIG_W-1:0] TRIG_LVL_LO = 3'd0;
    localparam logic [TRIG_W-1:0] TRIG_LVL_HI = 3'd1;
    localparam logic [TRIG_W-1:0] TRIG_FALL   = 3'd2;
    localparam logic [TRIG_W-1:0] TRIG_RISE   = 3'd4;
    localparam logic [TRIG_W-1:0] TRIG_BOTH   = 3'd6;

    typedef struct packed {
        logic              dout;
        logic              oen;
        logic              imask;
        logic              gmask;
        logic [TRIG_W-1:0] trig;
        logic [CNT_W-1:0]  fcnt;
        logic [PRE_W-1:0]  fpre;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        dout:  1'b0,
        oen:   1'b1,
        imask: 1'b1,
        gmask: 1'b1,
        trig:  TRIG_RISE,
        fcnt:  '0,
        fpre:  '0
    };

    // Neither edge bit set: the low bit selects the active level.
    function automatic logic trig_is_level(input logic [TRIG_W-1:0] t);
        return (t[2:1] == 2'b00);
    endfunction

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [CNT_W-1:0] cnt_lim,
    input  logic [PRE_W-1:0] pre_lim,
    output logic             dout
);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] stab_q;
    logic             tick;

    assign tick = (pre_q == pre_lim - PRE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            stab_q <= '0;
            dout   <= 1'b0;
        end else if (pre_lim == '0) begin
            pre_q  <= '0;
            stab_q <= '0;
            dout   <= din;
        end else if (din == dout) begin
            pre_q  <= '0;
            stab_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (stab_q == cnt_lim) begin
                stab_q <= '0;
                dout   <= din;
            end else begin
                stab_q <= stab_q + CNT_W'(1);
            end
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              level,
    input  logic [TRIG_W-1:0] trig,
    output logic              evt
);

    logic prev_q;
    logic rose;
    logic fell;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rose = level & ~prev_q;
    assign fell = ~level & prev_q;

    always_comb begin
        if (trig_is_level(trig)) evt = (level == trig[0]);
        else                     evt = (trig[2] & rose) | (trig[1] & fell);
    end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [PRE_W-1:0]  wdata,
    input  logic              pad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              irq_vis
);

    pin_cfg_t   cfg_q;
    logic [1:0] sync_q;
    logic       pend_q;
    logic       filt;
    logic       evt;
    logic       clr;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b00;
        else     sync_q <= {sync_q[0], pad_in};
    end

    gpio_debounce #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .din     (sync_q[1]),
        .cnt_lim (cfg_q.fcnt),
        .pre_lim (cfg_q.fpre),
        .dout    (filt)
    );

    gpio_trig_detect u_det (
        .clk   (clk),
        .rst   (rst),
        .level (filt),
        .trig  (cfg_q.trig),
        .evt   (evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            case (off)
                OFF_OUT:   cfg_q.dout  <= wdata[0];
                OFF_OEN:   cfg_q.oen   <= wdata[0];
                OFF_IMASK: cfg_q.imask <= wdata[0];
                OFF_GMASK: cfg_q.gmask <= wdata[0];
                OFF_TRIG:  cfg_q.trig  <= wdata[TRIG_W-1:0];
                OFF_FCNT:  cfg_q.fcnt  <= wdata[CNT_W-1:0];
                OFF_FPRE:  cfg_q.fpre  <= wdata;
                default:   ;
            endcase
        end
    end

    // A new event outranks a clear in the same cycle.
    assign clr = wr_en && (off == OFF_PEND) && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= evt | (pend_q & ~clr);
    end

    always_comb begin
        rd_data = '0;
        case (off)
            OFF_IN:    rd_data[0]          = sync_q[1];
            OFF_OUT:   rd_data[0]          = cfg_q.dout;
            OFF_OEN:   rd_data[0]          = cfg_q.oen;
            OFF_IMASK: rd_data[0]          = cfg_q.imask;
            OFF_GMASK: rd_data[0]          = cfg_q.gmask;
            OFF_PEND:  rd_data[0]          = pend_q;
            OFF_TRIG:  rd_data[TRIG_W-1:0] = cfg_q.trig;
            OFF_FCNT:  rd_data[CNT_W-1:0]  = cfg_q.fcnt;
            OFF_FPRE:  rd_data[PRE_W-1:0]  = cfg_q.fpre;
            default:   rd_data             = '0;
        endcase
    end

    assign pad_out = cfg_q.dout;
    assign pad_oe  = ~cfg_q.oen;
    assign irq_vis = pend_q & ~cfg_q.imask & ~cfg_q.gmask;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 49,
    parameter int GRP_SIZE = 16,
    parameter int ADDR_W   = 15
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          bus_sel,
    input  logic                                          bus_we,
    input  logic [ADDR_W-1:0]                             bus_addr,
    input  logic [DATA_W-1:0]                             bus_wdata,
    output logic [DATA_W-1:0]                             bus_rdata,
    input  logic [NUM_PINS-1:0]                           pad_in,
    output logic [NUM_PINS-1:0]                           pad_out,
    output logic [NUM_PINS-1:0]                           pad_oe,
    output logic [(NUM_PINS+GRP_SIZE-1)/GRP_SIZE-1:0]     grp_irq
);

    localparam int NGRP      = (NUM_PINS + GRP_SIZE - 1) / GRP_SIZE;
    localparam int PAD_W     = NGRP * GRP_SIZE;
    localparam int SUM_BIT   = ADDR_W - 1;
    localparam int PIN_IDX_W = SUM_BIT - 6;
    localparam int GRP_IDX_W = SUM_BIT - 2;

    logic                 is_sum;
    logic [PIN_IDX_W-1:0] pin_idx;
    logic [GRP_IDX_W-1:0] grp_idx;
    logic [OFF_W-1:0]     off;
    logic [DATA_W-1:0]    pin_rd [NUM_PINS];
    logic [NUM_PINS-1:0]  vis;
    logic [PAD_W-1:0]     vis_pad;
    logic                 unused_bits;

    assign is_sum  = bus_addr[SUM_BIT];
    assign pin_idx = bus_addr[SUM_BIT-1:6];
    assign grp_idx = bus_addr[SUM_BIT-1:2];
    assign off     = bus_addr[5:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:PRE_W]};

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic wr_en;
        assign wr_en = bus_sel && bus_we && !is_sum &&
                       (pin_idx == PIN_IDX_W'(p));

        gpio_pin_slice u_slice (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .off     (off),
            .wdata   (bus_wdata[PRE_W-1:0]),
            .pad_in  (pad_in[p]),
            .rd_data (pin_rd[p]),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p]),
            .irq_vis (vis[p])
        );
    end

    always_comb begin
        vis_pad                = '0;
        vis_pad[NUM_PINS-1:0]  = vis;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_irq[g] = |vis_pad[g*GRP_SIZE +: GRP_SIZE];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (is_sum) begin
                for (int g = 0; g < NGRP; g++) begin
                    if (grp_idx == GRP_IDX_W'(g))
                        bus_rdata[GRP_SIZE-1:0] = vis_pad[g*GRP_SIZE +: GRP_SIZE];
                end
            end else begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (pin_idx == PIN_IDX_W'(p))
                        bus_rdata = pin_rd[p];
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank_sva.sv
module gpio_bank_sva #(
    parameter int NUM_PINS = 49,
    parameter int GRP_SIZE = 16,
    parameter int ADDR_W   = 15,
    parameter int NGRP     = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NGRP-1:0]     grp_irq
);

    localparam int SUM_BIT   = ADDR_W - 1;
    localparam int PIN_IDX_W = SUM_BIT - 6;
    localparam int GRP_IDX_W = SUM_BIT - 2;

    logic [1:0] since_q;
    logic       unused_in;

    assign unused_in = ^{bus_wdata[31:1], pad_in[NUM_PINS-1:1], pad_out[NUM_PINS-1:1]};

    always_ff @(posedge clk) begin
        if (rst)                since_q <= 2'd0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    p_input_sync_r2: assert property (@(posedge clk) disable iff (rst)
        (since_q >= 2'd2 && bus_sel && !bus_we && bus_addr == '0)
        |-> bus_rdata == {31'b0, $past(pad_in[0], 2)});

    p_out_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == ADDR_W'(4))
        |=> pad_out[0] == $past(bus_wdata[0]));

    p_oe_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == ADDR_W'(8))
        |=> pad_oe[0] == !$past(bus_wdata[0]));

    p_reset_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (grp_irq == '0 && pad_oe == '0));

    p_unused_pin_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && !bus_addr[SUM_BIT] &&
         bus_addr[SUM_BIT-1:6] >= PIN_IDX_W'(NUM_PINS))
        |-> bus_rdata == '0);

    p_unused_grp_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr[SUM_BIT] &&
         bus_addr[SUM_BIT-1:2] >= GRP_IDX_W'(NGRP))
        |-> bus_rdata == '0);

endmodule

bind gpio_bank gpio_bank_sva #(
    .NUM_PINS (NUM_PINS),
    .GRP_SIZE (GRP_SIZE),
    .ADDR_W   (ADDR_W),
    .NGRP     ((NUM_PINS + GRP_SIZE - 1) / GRP_SIZE)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .grp_irq   (grp_irq)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

    localparam int NP = 49;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [14:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NG-1:0] grp_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .grp_irq   (grp_irq)
    );

    function automatic logic [14:0] pa(input int p, input int word);
        return 15'(p * 64 + word * 4);
    endfunction

    function automatic logic [14:0] sa(input int g);
        return 15'(16384 + g * 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_wr(input logic [14:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [14:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [14:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        chk("R4 pad_oe after reset", 32'(pad_oe[31:0]), 32'h0);
        chk("R4 grp_irq after reset", 32'(grp_irq), 32'h0);
        rd_chk("R4 oen reset", pa(0, 2), 32'h1);
        rd_chk("R4 imask reset", pa(0, 3), 32'h1);
        rd_chk("R4 gmask reset", pa(0, 4), 32'h1);
        rd_chk("R4 pending reset", pa(0, 5), 32'h0);
        rd_chk("R4 trig reset", pa(30, 6), 32'h4);
        rd_chk("R4 fpre reset", pa(48, 8), 32'h0);
    endtask

    task automatic t_decode;
        bus_wr(pa(20, 7), 32'hFFFF_FFA5);
        bus_wr(pa(20, 8), 32'h0000_1234);
        rd_chk("R1 fcnt readback", pa(20, 7), 32'hA5);
        rd_chk("R1 fpre readback", pa(20, 8), 32'h1234);
        rd_chk("R1 neighbour untouched", pa(21, 7), 32'h0);
        bus_wr(pa(20, 6), 32'h7);
        rd_chk("R1 trig readback", pa(20, 6), 32'h7);
        bus_wr(pa(20, 8), 32'h0);
        bus_wr(pa(20, 6), 32'h4);
    endtask

    task automatic t_input_sync;
        pad_in[7] = 1'b1;
        @(negedge clk);
        rd_chk("R2 input after one edge", pa(7, 0), 32'h0);
        rd_chk("R2 input after two edges", pa(7, 0), 32'h1);
        pad_in[7] = 1'b0;
        wait_cyc(3);
        rd_chk("R2 input low again", pa(7, 0), 32'h0);
    endtask

    task automatic t_direction;
        bus_wr(pa(2, 1), 32'h1);
        chk("R3 pad_out follows output reg", 32'(pad_out[2]), 32'h1);
        chk("R3 released while oen=1", 32'(pad_oe[2]), 32'h0);
        bus_wr(pa(2, 2), 32'h0);
        chk("R3 driven when oen=0", 32'(pad_oe[2]), 32'h1);
        rd_chk("R3 oen readback", pa(2, 2), 32'h0);
        bus_wr(pa(2, 2), 32'h1);
        chk("R3 released again", 32'(pad_oe[2]), 32'h0);
    endtask

    task automatic t_edges;
        bus_wr(pa(3, 6), 32'h2);
        pad_in[3] = 1'b1; wait_cyc(6);
        rd_chk("R5 falling mode ignores rise", pa(3, 5), 32'h0);
        pad_in[3] = 1'b0; wait_cyc(6);
        rd_chk("R5 falling mode latches fall", pa(3, 5), 32'h1);
        bus_wr(pa(3, 5), 32'h0);
        bus_wr(pa(3, 6), 32'h6);
        pad_in[3] = 1'b1; wait_cyc(6);
        rd_chk("R5 both mode rise", pa(3, 5), 32'h1);
        bus_wr(pa(3, 5), 32'h0);
        rd_chk("R7 clear after both-rise", pa(3, 5), 32'h0);
        pad_in[3] = 1'b0; wait_cyc(6);
        rd_chk("R5 both mode fall", pa(3, 5), 32'h1);
        bus_wr(pa(3, 5), 32'h0);
        bus_wr(pa(3, 6), 32'h4);
        pad_in[3] = 1'b1; wait_cyc(6);
        bus_wr(pa(3, 5), 32'h0);
        pad_in[3] = 1'b0; wait_cyc(6);
        rd_chk("R5 rising mode ignores fall", pa(3, 5), 32'h0);
    endtask

    task automatic t_levels;
        bus_wr(pa(4, 6), 32'h1);
        wait_cyc(4);
        rd_chk("R6 level-high idle low", pa(4, 5), 32'h0);
        pad_in[4] = 1'b1; wait_cyc(6);
        rd_chk("R6 level-high sets", pa(4, 5), 32'h1);
        bus_wr(pa(4, 5), 32'h0);
        rd_chk("R6 level re-asserts over clear", pa(4, 5), 32'h1);
        pad_in[4] = 1'b0; wait_cyc(6);
        bus_wr(pa(4, 5), 32'h0);
        rd_chk("R6 cleared once level gone", pa(4, 5), 32'h0);
        bus_wr(pa(4, 6), 32'h0);
        wait_cyc(3);
        rd_chk("R6 level-low sets", pa(4, 5), 32'h1);
        pad_in[4] = 1'b1; wait_cyc(6);
        bus_wr(pa(4, 5), 32'h0);
        rd_chk("R6 level-low inactive when high", pa(4, 5), 32'h0);
        bus_wr(pa(4, 6), 32'h4);
    endtask

    task automatic t_groups;
        pad_in[17] = 1'b1; wait_cyc(6);
        rd_chk("R7 pending set on pin 17", pa(17, 5), 32'h1);
        chk("R8 masked pin gives no irq", 32'(grp_irq), 32'h0);
        bus_wr(pa(17, 3), 32'h0);
        chk("R8 group mask still blocks", 32'(grp_irq), 32'h0);
        rd_chk("R9 summary hides half-masked pin", sa(1), 32'h0);
        bus_wr(pa(17, 4), 32'h0);
        chk("R8 both masks clear raise group 1", 32'(grp_irq), 32'h2);
        rd_chk("R9 summary group 1 bit 1", sa(1), 32'h2);
        rd_chk("R9 summary group 0 empty", sa(0), 32'h0);
        bus_wr(pa(17, 5), 32'h1);
        rd_chk("R7 writing one keeps pending", pa(17, 5), 32'h1);
        bus_wr(pa(17, 5), 32'h0);
        chk("R7 clear drops group line", 32'(grp_irq), 32'h0);
        bus_wr(pa(17, 5), 32'h1);
        rd_chk("R7 writing one does not set", pa(17, 5), 32'h0);
        pad_in[48] = 1'b1; wait_cyc(6);
        bus_wr(pa(48, 3), 32'h0);
        bus_wr(pa(48, 4), 32'h0);
        chk("R8 pin 48 drives group 3", 32'(grp_irq), 32'h8);
        rd_chk("R9 summary group 3 bit 0", sa(3), 32'h1);
        bus_wr(pa(48, 5), 32'h0);
        chk("R8 group 3 low after clear", 32'(grp_irq), 32'h0);
    endtask

    task automatic t_filter;
        bus_wr(pa(5, 8), 32'd2);
        bus_wr(pa(5, 7), 32'd1);
        pad_in[5] = 1'b1; wait_cyc(2);
        pad_in[5] = 1'b0; wait_cyc(8);
        rd_chk("R10 short pulse dropped", pa(5, 5), 32'h0);
        pad_in[5] = 1'b1; wait_cyc(4);
        rd_chk("R10 not yet through filter", pa(5, 5), 32'h0);
        rd_chk("R2 raw input unaffected by filter", pa(5, 0), 32'h1);
        wait_cyc(6);
        rd_chk("R10 steady level passes filter", pa(5, 5), 32'h1);
        bus_wr(pa(5, 5), 32'h0);
    endtask

    task automatic t_unused;
        bus_wr(pa(49, 1), 32'h1);
        rd_chk("R11 pin 49 window reads 0", pa(49, 1), 32'h0);
        chk("R11 write to pin 49 touches no pad", 32'(pad_out[31:0]), 32'h4);
        bus_wr(pa(0, 9), 32'hFFFF);
        rd_chk("R11 offset 0x24 reads 0", pa(0, 9), 32'h0);
        rd_chk("R11 group 4 summary reads 0", sa(4), 32'h0);
        bus_wr(sa(0), 32'hFFFF);
        rd_chk("R11 summary write ignored", sa(0), 32'h0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_decode();
        t_input_sync();
        t_direction();
        t_edges();
        t_levels();
        t_groups();
        t_filter();
        t_unused();
        wait_cyc(2);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule